// File: doc/BRIEF.md
# Delayed-Branch Fetch Sequencer

This block generates the fetch address for a five-stage in-order pipeline (fetch, decode, execute, memory access, write-back). It owns the program counter and the valid bit of the fetch/decode pipeline register. It resolves conditional branches while the branch sits in decode. The branch target comes from a dedicated adder that is separate from the execute-stage ALU, so a branch never waits for the execute stage.

Two control-flow policies are available, chosen by a mode pin that is captured only while reset is asserted.

- **Architectural delay slot.** The instruction fetched behind a branch always executes. The sequencer then continues at the target or at branch+8.
- **Predict-taken.** The sequencer always steers fetch to the target and discards the instruction behind the branch. The branch's test result is registered and applied one cycle later. If the branch proves not taken, the wrong-path instruction is discarded as well, and fetch returns to branch+4.

A discarded instruction only loses its valid bit, so it changes no architectural state.

The branch test looks at a single register: equal to zero, or not equal to zero. A stall input freezes the sequencer completely. A branch found in a delay slot is not supported. It is executed as a no-op and raises a sticky error flag.

Top module: `pcseq_top`

## Requirements
- R1: While reset is low and in the first cycle after it rises, `fetchPc` equals `RESET_VEC` and `ifidValid` is 0. `slotErr` is 0 after every reset.
- R2: In an unstalled cycle with no redirect, `fetchPc` advances by 4. The instruction fetched one cycle earlier is then valid in decode.
- R3: Delay-slot mode, taken branch. The instruction behind the branch stays valid, and the next fetch address is the branch address + 4 + sign-extended `immOff`×4.
- R4: Delay-slot mode, not-taken branch. The next fetch address is the branch address + 8. `squash` is never asserted in this mode.
- R5: `brKind` encoding:
  - 2'b00: no branch.
  - 2'b01: taken when `regVal` is 0.
  - 2'b10: taken when `regVal` is nonzero.
  - 2'b11: reserved and treated as no branch.
- R6: Predict-taken mode, branch valid in decode. `squash` is asserted in that cycle, and the next fetch address is the target regardless of `regVal`. If the branch was taken, no further squash follows.
- R7: Predict-taken mode, not-taken branch. In the cycle after the branch left decode, `squash` is asserted again, and the next fetch address is the branch address + 4.
- R8: While `stall` is 1:
  - `fetchPc`, `ifidValid` and all pending branch state hold.
  - `squash` is 0.
  - A branch in decode is acted on only in its first unstalled cycle.
- R9: In delay-slot mode, a branch in a delay slot acts as no branch, and `slotErr` rises. `slotErr` then stays 1 until reset.
- R10: `modeSel` (0 = delay slot, 1 = predict-taken) is sampled only during reset. Changing it afterwards has no effect.
- R11: After a cycle with `squash` asserted, `ifidValid` is 0. A branch code presented while `ifidValid` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 1 | Policy select, captured during reset: 0 delay slot, 1 predict-taken |
| stall | input | 1 | Freezes the sequencer for this cycle |
| brKind | input | 2 | Branch kind of the decode-stage instruction |
| regVal | input | XLEN | Register operand tested by the branch |
| immOff | input | OFFW | Signed word offset of the branch |
| fetchPc | output | XLEN | Address fetched this cycle |
| squash | output | 1 | Discard the instruction now being fetched |
| ifidValid | output | 1 | Decode-stage instruction is valid |
| slotErr | output | 1 | Sticky flag: a branch was found in a delay slot |

## Verification
The bench uses XLEN=32, OFFW=16 and a reset vector of 0x100. With these values, a negative offset can drive the target below the reset vector, which exercises sign extension across the full address width. The small reset vector keeps every expected address easy to derive by hand from the branch address. Each scenario starts from a fresh reset in the mode it needs, so the mode is flipped right after reset to show that it stays latched.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  typedef enum logic [1:0] {
    BR_NONE    = 2'b00,
    BR_ZERO    = 2'b01,
    BR_NONZERO = 2'b10,
    BR_RSVD    = 2'b11
  } brKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic adv;        // pipeline advances this cycle
    logic selTarget;  // next fetch from branch target
    logic selFall;    // next fetch from saved fall-through
    logic saveFall;   // remember fall-through address
  } seqStrobe_t;

endpackage

// File: rtl/pcseq_path.sv
module pcseq_path
  import pcseq_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int OFFW = 16,
  parameter logic [XLEN-1:0] RESET_VEC = 'h100
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [XLEN-1:0]  regVal,
  input  logic [OFFW-1:0]  immOff,
  output logic [XLEN-1:0]  fetchPc,
  output logic             regZero
);

  localparam int EXTW = XLEN - OFFW - 2;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] idPc;
  logic [XLEN-1:0] fallPc;
  logic [XLEN-1:0] seqPc;
  logic [XLEN-1:0] tgtPc;
  logic [XLEN-1:0] offBytes;
  logic [XLEN-1:0] nextPc;

  assign regZero  = (regVal == '0);
  assign offBytes = {{EXTW{immOff[OFFW-1]}}, immOff, 2'b00};
  assign seqPc    = fetchPc + STEP;
  // dedicated decode-stage target adder
  assign tgtPc    = idPc + STEP + offBytes;

  always_comb begin
    if (strobe.selTarget)    nextPc = tgtPc;
    else if (strobe.selFall) nextPc = fallPc;
    else                     nextPc = seqPc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fetchPc <= RESET_VEC;
      idPc    <= RESET_VEC;
      fallPc  <= RESET_VEC;
    end else if (strobe.adv) begin
      idPc    <= fetchPc;
      fetchPc <= nextPc;
      if (strobe.saveFall) fallPc <= fetchPc;
    end
  end

  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.adv && !strobe.selTarget && !strobe.selFall
      |=> fetchPc == $past(fetchPc) + STEP);

  a_r8_hold_pc: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.adv |=> $stable(fetchPc) && $stable(idPc));

  a_r7_refetch: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selFall && strobe.adv |=> fetchPc == $past(idPc));

  a_r6_single_source: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.selTarget, strobe.selFall}));

endmodule

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
  import pcseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeSel,
  input  logic       stall,
  input  logic [1:0] brKind,
  input  logic       regZero,
  output seqStrobe_t strobe,
  output logic       squash,
  output logic       idValid,
  output logic       slotErr
);

  logic    predMode;
  logic    inSlot;
  logic    pendChk;
  logic    pendTaken;
  brKind_e kind;
  logic    isCond;
  logic    condTrue;
  logic    brBad;
  logic    brAct;
  logic    missPred;

  assign kind = brKind_e'(brKind);

  always_comb begin
    isCond   = idValid && (kind == BR_ZERO || kind == BR_NONZERO);
    condTrue = (kind == BR_ZERO) ? regZero : !regZero;
    brBad    = !predMode && isCond && inSlot;
    brAct    = isCond && !brBad;
    missPred = predMode && pendChk && !pendTaken;

    strobe.adv       = !stall;
    strobe.selTarget = !stall && brAct && (predMode || condTrue);
    strobe.selFall   = !stall && missPred;
    strobe.saveFall  = !stall && predMode && brAct;
    squash           = !stall && predMode && (brAct || missPred);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      predMode  <= modeSel;
      idValid   <= 1'b0;
      inSlot    <= 1'b0;
      pendChk   <= 1'b0;
      pendTaken <= 1'b0;
      slotErr   <= 1'b0;
    end else if (!stall) begin
      idValid   <= !squash;
      inSlot    <= !predMode && brAct;
      pendChk   <= predMode && brAct;
      pendTaken <= condTrue;
      if (brBad) slotErr <= 1'b1;
    end
  end

  a_r10_mode_latched: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $stable(predMode));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    slotErr |=> slotErr);

  a_r4_no_squash_delay: assert property (@(posedge clk) disable iff (!rstN)
    !predMode |-> !squash);

  a_r8_stall_quiet: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !squash && !strobe.selTarget && !strobe.selFall);

  a_r8_stall_pending: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> $stable(pendChk) && $stable(inSlot) && $stable(idValid));

endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
  import pcseq_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int OFFW = 16,
  parameter logic [XLEN-1:0] RESET_VEC = 'h100
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            modeSel,
  input  logic            stall,
  input  logic [1:0]      brKind,
  input  logic [XLEN-1:0] regVal,
  input  logic [OFFW-1:0] immOff,
  output logic [XLEN-1:0] fetchPc,
  output logic            squash,
  output logic            ifidValid,
  output logic            slotErr
);

  seqStrobe_t strobe;
  logic       regZero;

  pcseq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel (modeSel),
    .stall   (stall),
    .brKind  (brKind),
    .regZero (regZero),
    .strobe  (strobe),
    .squash  (squash),
    .idValid (ifidValid),
    .slotErr (slotErr)
  );

  pcseq_path #(
    .XLEN      (XLEN),
    .OFFW      (OFFW),
    .RESET_VEC (RESET_VEC)
  ) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .regVal  (regVal),
    .immOff  (immOff),
    .fetchPc (fetchPc),
    .regZero (regZero)
  );

  a_r11_squash_bubble: assert property (@(posedge clk) disable iff (!rstN)
    squash |=> !ifidValid);

endmodule

// File: tb/pcseq_top_test.sv
`timescale 1ns/1ps
module pcseq_top_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        modeSel;
  logic        stall;
  logic [1:0]  brKind;
  logic [31:0] regVal;
  logic [15:0] immOff;
  logic [31:0] fetchPc;
  logic        squash;
  logic        ifidValid;
  logic        slotErr;

  int nChecks = 0;
  int nErr    = 0;

  always #4 clk = ~clk;  // 125 MHz

  pcseq_top #(.XLEN(32), .OFFW(16), .RESET_VEC(32'h100)) uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .stall(stall),
    .brKind(brKind), .regVal(regVal), .immOff(immOff),
    .fetchPc(fetchPc), .squash(squash), .ifidValid(ifidValid),
    .slotErr(slotErr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic [1:0] k, input logic [31:0] r, input logic [15:0] o);
    brKind = k;
    regVal = r;
    immOff = o;
    #1;
  endtask

  // modeSel is flipped right after reset to probe R10
  task automatic doReset(input logic m);
    rstN = 1'b0; modeSel = m; stall = 1'b0;
    brKind = 2'b00; regVal = '0; immOff = '0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 pc in reset", fetchPc, 32'h100);
    chk("R1 valid in reset", ifidValid, 1'b0);
    rstN = 1'b1;
    modeSel = ~m;
    #1;
  endtask

  task automatic testReset;
    doReset(1'b0);
    chk("R1 pc after reset", fetchPc, 32'h100);
    chk("R1 valid first cycle", ifidValid, 1'b0);
    chk("R1 err clear", slotErr, 1'b0);
    tick;
    chk("R2 step", fetchPc, 32'h104);
    chk("R2 valid", ifidValid, 1'b1);
    tick;
    chk("R2 step2", fetchPc, 32'h108);
  endtask

  task automatic testDelayTaken;
    doReset(1'b0);
    tick;                         // decode holds 0x100
    drive(2'b01, 32'd0, 16'd3);   // target 0x110
    chk("R4 no squash", squash, 1'b0);
    tick;
    chk("R3 target", fetchPc, 32'h110);
    chk("R3 slot valid", ifidValid, 1'b1);
    drive(2'b00, 32'd0, 16'd0);
    tick;
    chk("R3 after target", fetchPc, 32'h114);
  endtask

  task automatic testDelayNotTaken;
    doReset(1'b0);
    tick;
    drive(2'b01, 32'd5, 16'd3);
    chk("R4 no squash nt", squash, 1'b0);
    tick;
    chk("R4 b+8", fetchPc, 32'h108);
    chk("R4 slot valid", ifidValid, 1'b1);
    drive(2'b00, 32'd0, 16'd0);
    tick;
    chk("R4 seq", fetchPc, 32'h10C);
  endtask

  task automatic testKinds;
    doReset(1'b0);
    tick;
    drive(2'b10, 32'd7, 16'hFFFE); // 0x100+4-8
    tick;
    chk("R5 nonzero taken neg", fetchPc, 32'h0FC);
    drive(2'b00, 32'd0, 16'd0);
    tick;                           // decode 0xFC
    drive(2'b10, 32'd0, 16'd3);     // not taken
    tick;
    chk("R5 nonzero not taken", fetchPc, 32'h104);
    drive(2'b00, 32'd0, 16'd0);
    tick;                           // decode 0x104
    drive(2'b11, 32'd0, 16'd3);
    tick;
    chk("R5 reserved ignored", fetchPc, 32'h10C);
    chk("R5 reserved no err", slotErr, 1'b0);
  endtask

  task automatic testSlotBranch;
    doReset(1'b0);
    tick;
    drive(2'b01, 32'd0, 16'd3);
    tick;                           // decode 0x104 (slot), fetch 0x110
    drive(2'b01, 32'd0, 16'd5);
    tick;
    chk("R9 slot branch no-op", fetchPc, 32'h114);
    chk("R9 err raised", slotErr, 1'b1);
    drive(2'b00, 32'd0, 16'd0);
    tick;
    chk("R9 seq", fetchPc, 32'h118);
    chk("R9 err sticky", slotErr, 1'b1);
    doReset(1'b0);
    chk("R1 err cleared", slotErr, 1'b0);
  endtask

  task automatic testStallDelay;
    doReset(1'b0);
    tick;
    stall = 1'b1;
    drive(2'b01, 32'd0, 16'd3);
    chk("R8 no squash stalled", squash, 1'b0);
    tick;
    chk("R8 pc hold", fetchPc, 32'h104);
    chk("R8 valid hold", ifidValid, 1'b1);
    tick;
    chk("R8 pc hold2", fetchPc, 32'h104);
    stall = 1'b0;
    tick;
    chk("R8 branch after stall", fetchPc, 32'h110);
  endtask

  task automatic testPredTaken;
    doReset(1'b1);
    tick;
    drive(2'b01, 32'd0, 16'd3);
    chk("R6 squash", squash, 1'b1);
    tick;
    chk("R6 target", fetchPc, 32'h110);
    chk("R11 bubble", ifidValid, 1'b0);
    drive(2'b01, 32'd0, 16'd5);     // on a bubble: ignored
    chk("R6 no second squash", squash, 1'b0);
    tick;
    chk("R11 bubble branch ignored", fetchPc, 32'h114);
    chk("R6 target valid", ifidValid, 1'b1);
    drive(2'b00, 32'd0, 16'd0);
  endtask

  task automatic testPredNotTaken;
    doReset(1'b1);
    tick;
    drive(2'b01, 32'd9, 16'd3);
    chk("R6 squash nt", squash, 1'b1);
    tick;
    chk("R6 target nt", fetchPc, 32'h110);
    drive(2'b00, 32'd0, 16'd0);
    chk("R7 second squash", squash, 1'b1);
    tick;
    chk("R7 refetch", fetchPc, 32'h104);
    chk("R11 bubble nt", ifidValid, 1'b0);
    tick;
    chk("R7 seq", fetchPc, 32'h108);
    chk("R7 valid", ifidValid, 1'b1);
  endtask

  task automatic testPredStall;
    doReset(1'b1);
    tick;
    drive(2'b01, 32'd9, 16'd3);
    tick;
    drive(2'b00, 32'd0, 16'd0);
    stall = 1'b1;
    #1;
    chk("R8 squash gated", squash, 1'b0);
    tick;
    chk("R8 pending hold", fetchPc, 32'h110);
    stall = 1'b0;
    #1;
    chk("R8 pending kept", squash, 1'b1);
    tick;
    chk("R8 refetch after stall", fetchPc, 32'h104);
  endtask

  initial begin
    #800000;
    nErr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    testReset;
    testDelayTaken;
    testDelayNotTaken;
    testKinds;
    testSlotBranch;
    testStallDelay;
    testPredTaken;
    testPredNotTaken;
    testPredStall;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule